// File: doc/BRIEF.md
# Alarm, Periodic and Power-Fail Interrupt Controller

This block collects three interrupt sources of a real-time-clock peripheral and merges them into one active-low request line. The first source is a time-of-day alarm. On each one-second tick it compares the current BCD seconds, minutes, hours and date against alarm values. Each field carries its own two-bit mask, so the alarm can repeat at any rate from every second to once a month. The second source is a periodic event. It comes from a free-running divider that counts 32.768 kHz reference ticks, with a rate code that selects a power-of-two period. The third source is a power-fail pulse from the supply monitor.

Each source has a sticky flag and an enable bit. A fourth enable lets the alarm wake the system while the chip runs from its backup cell. All other sources are silenced in that mode. Reading the flag register clears every flag. Time counting and the host bus decoding are handled elsewhere; this block only sees decoded write and read strobes.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the enable register and all flags are 0 and `irq_n` is high.
- R2: A `ctrl_wr` strobe loads `ctrl_wdata` into the enable register on that clock edge. Bit 3 is the alarm enable, bit 2 the periodic enable, bit 1 the power-fail enable and bit 0 the backup-mode alarm enable. The register is visible on `ctrl_q`.
- R3: The alarm flag (`flags_q` bit 2) sets on a clock edge where `tick_sec` is high and every unmasked field matches. Without `tick_sec` it never sets.
- R4: A field is a don't-care only when both of its mask bits are 1. A mask of 01 or 10 still compares the field. Fields are packed sec, min, hour, date from the least significant byte up, and mask bits [2i+1:2i] belong to field i.
- R5: The hours field is compared over all 8 bits, so the PM flag in bit 7 must match too.
- R6: With `rate` = n (1..15), the periodic flag (bit 1) sets on every 2^(n-1)-th `tick_ref` counted from reset. With `rate` = 0 it never sets.
- R7: A `pwr_fail` pulse sets the power-fail flag (bit 0).
- R8: Outside backup mode, `irq_n` goes low one clock after an enabled flag is set. A flag whose enable is clear does not pull it low.
- R9: A `flags_rd` strobe clears all flags on that edge, and `irq_n` is released one clock later. An event arriving in the same cycle as the strobe is kept.
- R10: While `backup` is high, `irq_n` is driven only by the alarm flag ANDed with the backup-mode alarm enable. The alarm enable alone, the periodic source and the power-fail source do not assert it.
- R11: A set flag stays set until a `flags_rd` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ref | input | 1 | One-cycle pulse per 32.768 kHz reference period |
| tick_sec | input | 1 | One-cycle pulse per second |
| cur_time | input | 32 | Current BCD time {date, hour, min, sec} |
| alm_time | input | 32 | Alarm BCD values, same packing |
| alm_mask | input | 8 | Two mask bits per field |
| rate | input | 4 | Periodic rate code |
| pwr_fail | input | 1 | Power-fail event pulse |
| backup | input | 1 | High while running from the backup cell |
| ctrl_wr | input | 1 | Enable register write strobe |
| ctrl_wdata | input | 4 | Enable register write data |
| flags_rd | input | 1 | Flag register read strobe (clears flags) |
| ctrl_q | output | 4 | Enable register contents |
| flags_q | output | 3 | Flags {alarm, periodic, power-fail} |
| irq_n | output | 1 | Shared active-low interrupt request |

## Verification
The properties assume that `tick_sec`, `tick_ref`, `pwr_fail` and the two strobes are single-cycle pulses synchronous to `clk`. They also assume that `rate` and the alarm inputs stay stable around a tick. The bench drives every input on the falling edge and holds each pulse for exactly one clock. It changes time, alarm and mask values only in cycles with no tick. Divider-phase checks start from a fresh reset, so the tick count since reset is always known.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   localparam int FLG_PWR = 0;
   localparam int FLG_PER = 1;
   localparam int FLG_ALM = 2;
   localparam int N_FLG   = 3;

   localparam int EN_BKALM = 0;
   localparam int EN_PWR   = 1;
   localparam int EN_PER   = 2;
   localparam int EN_ALM   = 3;
   localparam int N_EN     = 4;
endpackage

// File: rtl/irq_alarm_cmp.sv
module irq_alarm_cmp #(
   parameter int FIELD_W  = 8,
   parameter int N_FIELDS = 4
) (
   input  logic [FIELD_W*N_FIELDS-1:0] cur,
   input  logic [FIELD_W*N_FIELDS-1:0] alm,
   input  logic [2*N_FIELDS-1:0]       mask,
   output logic                        hit
);
   logic [N_FIELDS-1:0] fld_ok;

   for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
      logic dont_care;
      assign dont_care = mask[2*g+1] & mask[2*g];
      assign fld_ok[g] = dont_care ||
                         (cur[g*FIELD_W +: FIELD_W] == alm[g*FIELD_W +: FIELD_W]);
   end

   assign hit = &fld_ok;
endmodule

// File: rtl/irq_rate_div.sv
module irq_rate_div #(
   parameter int RATE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [RATE_W-1:0] rate,
   output logic              evt
);
   localparam int DIV_W = (1 << RATE_W) - 2;

   if (RATE_W < 2 || RATE_W > 5) begin : g_bad_rate_w
      $error("irq_rate_div: RATE_W must be 2..5");
   end

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] one_hot;
   logic [DIV_W-1:0] sel_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end

   always_comb begin
      one_hot  = DIV_W'(1) << (rate - RATE_W'(1));
      sel_mask = one_hot - 1'b1;
      evt      = tick && (rate != '0) && ((cnt & sel_mask) == sel_mask);
   end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr,
   output logic [N-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~{N{clr}}) | set;
   end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int FIELD_W  = 8,
   parameter int N_FIELDS = 4,
   parameter int RATE_W   = 4,
   parameter bit REG_IRQ  = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        tick_ref,
   input  logic                        tick_sec,
   input  logic [FIELD_W*N_FIELDS-1:0] cur_time,
   input  logic [FIELD_W*N_FIELDS-1:0] alm_time,
   input  logic [2*N_FIELDS-1:0]       alm_mask,
   input  logic [RATE_W-1:0]           rate,
   input  logic                        pwr_fail,
   input  logic                        backup,
   input  logic                        ctrl_wr,
   input  logic [N_EN-1:0]             ctrl_wdata,
   input  logic                        flags_rd,
   output logic [N_EN-1:0]             ctrl_q,
   output logic [N_FLG-1:0]            flags_q,
   output logic                        irq_n
);
   if (FIELD_W < 1 || N_FIELDS < 1) begin : g_bad_fields
      $error("irq_ctrl: FIELD_W and N_FIELDS must be positive");
   end

   logic             alm_hit;
   logic             per_evt;
   logic [N_FLG-1:0] flag_set;
   logic             irq_req;

   irq_alarm_cmp #(.FIELD_W(FIELD_W), .N_FIELDS(N_FIELDS)) u_cmp (
      .cur(cur_time), .alm(alm_time), .mask(alm_mask), .hit(alm_hit)
   );

   irq_rate_div #(.RATE_W(RATE_W)) u_div (
      .clk(clk), .rst_n(rst_n), .tick(tick_ref), .rate(rate), .evt(per_evt)
   );

   always_comb begin
      flag_set          = '0;
      flag_set[FLG_ALM] = alm_hit & tick_sec;
      flag_set[FLG_PER] = per_evt;
      flag_set[FLG_PWR] = pwr_fail;
   end

   irq_flag_bank #(.N(N_FLG)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flags_rd), .q(flags_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= ctrl_wdata;
   end

   always_comb begin
      if (backup)
         irq_req = flags_q[FLG_ALM] & ctrl_q[EN_BKALM];
      else
         irq_req = (flags_q[FLG_ALM] & ctrl_q[EN_ALM]) |
                   (flags_q[FLG_PER] & ctrl_q[EN_PER]) |
                   (flags_q[FLG_PWR] & ctrl_q[EN_PWR]);
   end

   if (REG_IRQ) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_n <= 1'b1;
         else        irq_n <= ~irq_req;
      end
   end else begin : g_irq_comb
      assign irq_n = ~irq_req;
   end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
   import irq_ctrl_pkg::*;
#(
   parameter int RATE_W  = 4,
   parameter bit REG_IRQ = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_sec,
   input logic [RATE_W-1:0] rate,
   input logic              pwr_fail,
   input logic              backup,
   input logic              flags_rd,
   input logic [N_EN-1:0]   ctrl_q,
   input logic [N_FLG-1:0]  flags_q,
   input logic              irq_n
);
   // R3: the alarm flag only rises after a second tick
   a_r3_alarm_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_q[FLG_ALM]) |-> $past(tick_sec));

   // R6: rate code 0 never raises the periodic flag
   a_r6_rate_off: assert property (@(posedge clk) disable iff (!rst_n)
      (rate == '0 && !flags_q[FLG_PER]) |=> !flags_q[FLG_PER]);

   // R9: a read with no new power-fail event clears that flag
   a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_rd && !pwr_fail) |=> !flags_q[FLG_PWR]);

   // R11: a set flag holds until read
   a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[FLG_PWR] && !flags_rd) |=> flags_q[FLG_PWR]);

   if (REG_IRQ) begin : g_reg
      // R8: no flags means the request is released next cycle
      a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
         (flags_q == '0) |=> irq_n);
      // R10: in backup mode without the backup alarm enable the line stays high
      a_r10_backup_gate: assert property (@(posedge clk) disable iff (!rst_n)
         (backup && !ctrl_q[EN_BKALM]) |=> irq_n);
   end else begin : g_comb
      a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
         (flags_q == '0) |-> irq_n);
      a_r10_backup_gate: assert property (@(posedge clk) disable iff (!rst_n)
         (backup && !ctrl_q[EN_BKALM]) |-> irq_n);
   end
endmodule

bind irq_ctrl irq_ctrl_chk #(.RATE_W(RATE_W), .REG_IRQ(REG_IRQ)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec), .rate(rate),
   .pwr_fail(pwr_fail), .backup(backup), .flags_rd(flags_rd),
   .ctrl_q(ctrl_q), .flags_q(flags_q), .irq_n(irq_n)
);

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_ref = 1'b0, tick_sec = 1'b0;
   logic [31:0] cur_time = '0, alm_time = '0;
   logic [7:0]  alm_mask = '0;
   logic [3:0]  rate = '0;
   logic        pwr_fail = 1'b0, backup = 1'b0;
   logic        ctrl_wr = 1'b0, flags_rd = 1'b0;
   logic [3:0]  ctrl_wdata = '0;
   logic [3:0]  ctrl_q;
   logic [2:0]  flags_q;
   logic        irq_n;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .tick_ref(tick_ref), .tick_sec(tick_sec),
      .cur_time(cur_time), .alm_time(alm_time), .alm_mask(alm_mask),
      .rate(rate), .pwr_fail(pwr_fail), .backup(backup),
      .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .flags_rd(flags_rd),
      .ctrl_q(ctrl_q), .flags_q(flags_q), .irq_n(irq_n)
   );

   task automatic check(input int act, input int exp, input string tag);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick_ref = 0; tick_sec = 0; pwr_fail = 0;
      backup = 0; ctrl_wr = 0; flags_rd = 0; rate = 0;
      alm_mask = 0; cur_time = 0; alm_time = 0;
      step(3);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic wr_ctrl(input logic [3:0] v);
      ctrl_wr = 1; ctrl_wdata = v; step(1); ctrl_wr = 0;
   endtask

   task automatic sec_tick();   tick_sec = 1; step(1); tick_sec = 0; endtask
   task automatic ref_tick();   tick_ref = 1; step(1); tick_ref = 0; step(1); endtask
   task automatic rd_flags();   flags_rd = 1; step(1); flags_rd = 0; endtask
   task automatic pf_pulse();   pwr_fail = 1; step(1); pwr_fail = 0; endtask

   task automatic t_reset();
      do_reset();
      check(ctrl_q, 0, "R1 ctrl");
      check(flags_q, 0, "R1 flags");
      check(irq_n, 1, "R1 irq_n");
   endtask

   task automatic t_ctrl();
      do_reset();
      wr_ctrl(4'b1010);
      check(ctrl_q, 4'b1010, "R2 write a");
      wr_ctrl(4'b0101);
      check(ctrl_q, 4'b0101, "R2 write b");
   endtask

   task automatic t_alarm();
      do_reset();
      cur_time = 32'h15_09_30_45;
      alm_time = 32'h15_09_30_45;
      step(3);
      check(flags_q, 0, "R3 no tick no flag");
      sec_tick();
      check(flags_q[2], 1, "R3 match sets alarm flag");
      rd_flags();
      cur_time = 32'h15_09_30_46;
      sec_tick();
      check(flags_q[2], 0, "R3 mismatch");
   endtask

   task automatic t_mask();
      do_reset();
      cur_time = 32'h15_09_30_46;
      alm_time = 32'h15_09_30_00;
      alm_mask = 8'b00_00_00_11;
      sec_tick();
      check(flags_q[2], 1, "R4 sec masked");
      rd_flags();
      alm_mask = 8'b00_00_00_01;
      sec_tick();
      check(flags_q[2], 0, "R4 half mask compares");
      alm_time = 32'h01_01_01_01;
      alm_mask = 8'hFF;
      sec_tick();
      check(flags_q[2], 1, "R4 all masked");
   endtask

   task automatic t_pm();
      do_reset();
      cur_time = 32'h15_09_30_45;
      alm_time = 32'h15_89_30_45;
      sec_tick();
      check(flags_q[2], 0, "R5 PM bit differs");
      cur_time = 32'h15_89_30_45;
      sec_tick();
      check(flags_q[2], 1, "R5 PM bit matches");
   endtask

   task automatic t_periodic();
      do_reset();
      rate = 4'd3;
      for (int i = 0; i < 3; i++) ref_tick();
      check(flags_q[1], 0, "R6 rate3 before 4th tick");
      ref_tick();
      check(flags_q[1], 1, "R6 rate3 at 4th tick");
      do_reset();
      rate = 4'd1;
      ref_tick();
      check(flags_q[1], 1, "R6 rate1 every tick");
      do_reset();
      rate = 4'd0;
      for (int i = 0; i < 20; i++) ref_tick();
      check(flags_q[1], 0, "R6 rate0 off");
      do_reset();
      rate = 4'd15;
      for (int i = 0; i < 16383; i++) ref_tick();
      check(flags_q[1], 0, "R6 rate15 before 16384");
      ref_tick();
      check(flags_q[1], 1, "R6 rate15 at 16384");
   endtask

   task automatic t_pwr();
      do_reset();
      pf_pulse();
      check(flags_q, 3'b001, "R7 power flag");
      step(2);
      check(irq_n, 1, "R8 disabled source");
      step(10);
      check(flags_q, 3'b001, "R11 sticky");
   endtask

   task automatic t_irq_read();
      do_reset();
      wr_ctrl(4'b0010);
      pf_pulse();
      check(irq_n, 1, "R8 not yet");
      step(1);
      check(irq_n, 0, "R8 asserted");
      rd_flags();
      check(flags_q, 0, "R9 cleared");
      check(irq_n, 0, "R9 release lag");
      step(1);
      check(irq_n, 1, "R9 released");
      flags_rd = 1; pwr_fail = 1; step(1); flags_rd = 0; pwr_fail = 0;
      check(flags_q, 3'b001, "R9 set wins");
   endtask

   task automatic t_backup();
      do_reset();
      backup = 1;
      alm_mask = 8'hFF;
      wr_ctrl(4'b1000);
      sec_tick();
      step(2);
      check(irq_n, 1, "R10 alarm enable alone");
      wr_ctrl(4'b1001);
      step(1);
      check(irq_n, 0, "R10 backup alarm enable");
      do_reset();
      backup = 1;
      wr_ctrl(4'b0010);
      pf_pulse();
      step(2);
      check(irq_n, 1, "R10 power gated");
      backup = 0;
      step(2);
      check(irq_n, 0, "R10 leave backup");
   endtask

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_ctrl();
      t_alarm();
      t_mask();
      t_pm();
      t_periodic();
      t_pwr();
      t_irq_read();
      t_backup();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule